// File: doc/BRIEF.md
# Word FIFO Mailbox Channel with Watermark

This block carries 32-bit words one way, from a sending agent to a receiving agent. The sender uses a write-only access port (port A). Writing the push address appends a word to the queue, writing the level-mark address sets the watermark, and writing the flush address can empty the channel. The receiver uses a read-only access port (port B). Reading the pop address removes the oldest word. The status and watermark addresses can be read with no side effect. Read data on port B is combinational, so it is valid in the same cycle as the access.

The channel keeps a set of status flags and produces one-cycle interrupt event pulses. These pulses go to a shared status/enable/clear interrupt unit outside this block. A sender programs the watermark to the length of each message and then pushes the message. The receiver drains the queue when the watermark-rising or full event fires. The sender learns that the message was consumed when the empty event fires. Overflow and underflow are sticky errors. Only a flush clears them.

A small level state machine tracks the fill condition. Its states are LVL_EMPTY, LVL_PART and LVL_FULL. Its transitions are:
- fill_first, from LVL_EMPTY to LVL_PART.
- fill_last, from LVL_PART to LVL_FULL.
- drain_last, from LVL_PART to LVL_EMPTY.
- drain_from_full, from LVL_FULL to LVL_PART.
- flush, from any state to LVL_EMPTY.
- hold, a self-loop in every state.

The fill_first, fill_last and drain_last transitions each raise an event. The drain_from_full, flush and hold transitions raise none.

Top module: `mbx_word_fifo`

## Requirements
- R1: After reset the queue is empty, the status word at 0xB4 reads 0x4, the watermark at 0xB8 reads 32, and all event bits are 0.
- R2: A port B read of 0xB0 on a non-empty queue returns the oldest pushed word and removes it. Words leave in the order they were pushed by port A writes to 0xAC.
- R3: A push while the queue holds DEPTH words and no pop happens in the same cycle is dropped. It sets sticky status bit 4 (overflow) and pulses event bit 6.
- R4: A pop while the queue is empty returns 0. It sets sticky status bit 3 (underflow) and pulses event bit 7.
- R5: Status bit 0 is 1 when the level is at least the watermark. Bit 1 is 1 when the level equals DEPTH. Bit 2 is 1 when the level is 0. Bits above 4 read 0.
- R6: Event bit 4 pulses when status bit 0 goes from 0 to 1, and event bit 5 pulses when it goes from 1 to 0. This includes changes caused by a port A write of a new watermark to 0xB8.
- R7: Event bit 8 pulses when a word enters an empty queue. Event bit 2 pulses when the level reaches DEPTH.
- R8: Event bit 3 pulses in the cycle after the pop that removes the last word.
- R9: A port A write to 0xCC with data bit 0 set empties the queue, clears both sticky errors, keeps the watermark and raises no event. The same write with bit 0 clear has no effect.
- R10: A push and a pop in the same cycle leave the level unchanged. When the queue is full, this push is accepted without overflow.
- R11: A port A write to 0xB8 sets the watermark, and a port B read of 0xB8 returns it.
- R12: Every event is a pulse that is 1 for exactly the one cycle after the clock edge that caused it. Event bits 0 and 1 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr | input | 1 | Port A write strobe |
| a_addr | input | AW_BUS | Port A byte address |
| a_wdata | input | DW | Port A write data |
| b_rd | input | 1 | Port B read strobe; side effect only at 0xB0 |
| b_addr | input | AW_BUS | Port B byte address |
| b_rdata | output | DW | Port B read data, combinational |
| irq_evt | output | 9 | One-cycle interrupt event pulses, bit positions as in R3, R4, R6, R7, R8 |

## Verification
On every cycle the assertions check several properties:
- The level never exceeds DEPTH.
- An underflowing read returns zero and raises its event.
- An overflowing push leaves the level at DEPTH.
- The two watermark events never fire together.
- The empty and not-empty events agree with the level.
- A flush clears the queue silently.
- A simultaneous push and pop keeps the level.
- The sticky errors hold until a flush.

Only the bench scenarios can show some behaviours:
- Word ordering across wrap-around of the storage.
- The exact status word after long mixed sequences.
- Watermark edges caused by rewriting the watermark.
- That a flush write with bit 0 clear does nothing.

// File: rtl/mbx_word_fifo_pkg.sv
package mbx_word_fifo_pkg;

    // byte addresses on both access ports
    localparam logic [7:0] ADDR_PUSH  = 8'hAC;
    localparam logic [7:0] ADDR_POP   = 8'hB0;
    localparam logic [7:0] ADDR_STAT  = 8'hB4;
    localparam logic [7:0] ADDR_WMARK = 8'hB8;
    localparam logic [7:0] ADDR_FLUSH = 8'hCC;

    // interrupt event bit positions, decoded by the shared interrupt unit
    localparam int EV_FULL   = 2;
    localparam int EV_EMPTY  = 3;
    localparam int EV_WMRISE = 4;
    localparam int EV_WMFALL = 5;
    localparam int EV_OFLOW  = 6;
    localparam int EV_UFLOW  = 7;
    localparam int EV_NEMPTY = 8;
    localparam int EV_W      = 9;

    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_PART  = 2'd1,
        LVL_FULL  = 2'd2
    } lvl_e;

endpackage

// File: rtl/mbx_word_store.sv
module mbx_word_store #(
    parameter  int DW    = 32,
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_ok,
    input  logic          pop_ok,
    input  logic [DW-1:0] push_word,
    output logic [DW-1:0] head_word,
    output logic [CW-1:0] level
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] level_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem_q[wr_ptr_q] <= push_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            unique case ({push_ok, pop_ok})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    assign head_word = mem_q[rd_ptr_q];
    assign level     = level_q;

endmodule

// File: rtl/mbx_level_fsm.sv
module mbx_level_fsm
    import mbx_word_fifo_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int CW     = 6,
    parameter int WM_RST = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [CW-1:0]   level_nxt,
    input  logic [CW-1:0]   wm_nxt,
    input  logic            ovf_hit,
    input  logic            unf_hit,
    output logic            wm_reached,
    output logic [EV_W-1:0] evt
);

    lvl_e st_q, st_d;
    logic wm_q, wm_d;
    logic [EV_W-1:0] evt_q;

    // next-state decode
    always_comb begin
        if (level_nxt == '0)                 st_d = LVL_EMPTY;
        else if (level_nxt == CW'(DEPTH))    st_d = LVL_FULL;
        else                                 st_d = LVL_PART;
        wm_d = (level_nxt >= wm_nxt);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LVL_EMPTY;
            wm_q <= (WM_RST == 0);
        end else begin
            st_q <= st_d;
            wm_q <= wm_d;
        end
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= '0;
            if (!flush) begin
                unique case (st_q)
                    LVL_EMPTY: if (st_d != LVL_EMPTY) evt_q[EV_NEMPTY] <= 1'b1;
                    LVL_PART: begin
                        if (st_d == LVL_FULL)  evt_q[EV_FULL]  <= 1'b1;
                        if (st_d == LVL_EMPTY) evt_q[EV_EMPTY] <= 1'b1;
                    end
                    LVL_FULL: ;
                    default: ;
                endcase
                evt_q[EV_WMRISE] <= wm_d && !wm_q;
                evt_q[EV_WMFALL] <= !wm_d && wm_q;
                evt_q[EV_OFLOW]  <= ovf_hit;
                evt_q[EV_UFLOW]  <= unf_hit;
            end
        end
    end

    assign wm_reached = wm_q;
    assign evt        = evt_q;

endmodule

// File: rtl/mbx_word_fifo.sv
module mbx_word_fifo
    import mbx_word_fifo_pkg::*;
#(
    parameter  int DW     = 32,
    parameter  int DEPTH  = 32,
    parameter  int WM_RST = 32,
    parameter  int AW_BUS = 8,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic [AW_BUS-1:0] a_addr,
    input  logic [DW-1:0]     a_wdata,
    input  logic              b_rd,
    input  logic [AW_BUS-1:0] b_addr,
    output logic [DW-1:0]     b_rdata,
    output logic [EV_W-1:0]   irq_evt
);

    logic          push_req, pop_req, flush_req, wm_wr;
    logic          push_ok, pop_ok, ovf_hit, unf_hit;
    logic          lvl_full, lvl_empty, wm_reached;
    logic          ovf_q, unf_q;
    logic [CW-1:0] level, level_nxt, wm_q, wm_nxt;
    logic [DW-1:0] head_word, stat_word;

    // access decode
    assign push_req  = a_wr && (a_addr == AW_BUS'(ADDR_PUSH));
    assign wm_wr     = a_wr && (a_addr == AW_BUS'(ADDR_WMARK));
    assign flush_req = a_wr && (a_addr == AW_BUS'(ADDR_FLUSH)) && a_wdata[0];
    assign pop_req   = b_rd && (b_addr == AW_BUS'(ADDR_POP));

    assign lvl_full  = (level == CW'(DEPTH));
    assign lvl_empty = (level == '0);
    assign pop_ok    = pop_req && !lvl_empty && !flush_req;
    assign push_ok   = push_req && (!lvl_full || pop_ok) && !flush_req;
    assign ovf_hit   = push_req && !push_ok && !flush_req;
    assign unf_hit   = pop_req && lvl_empty && !flush_req;

    assign level_nxt = flush_req ? '0 : level + CW'(push_ok) - CW'(pop_ok);
    assign wm_nxt    = wm_wr ? a_wdata[CW-1:0] : wm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wm_q  <= CW'(WM_RST);
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            wm_q <= wm_nxt;
            if (flush_req) begin
                ovf_q <= 1'b0;
                unf_q <= 1'b0;
            end else begin
                ovf_q <= ovf_q | ovf_hit;
                unf_q <= unf_q | unf_hit;
            end
        end
    end

    mbx_word_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_req),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .push_word (a_wdata),
        .head_word (head_word),
        .level     (level)
    );

    mbx_level_fsm #(.DEPTH(DEPTH), .CW(CW), .WM_RST(WM_RST)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_req),
        .level_nxt  (level_nxt),
        .wm_nxt     (wm_nxt),
        .ovf_hit    (ovf_hit),
        .unf_hit    (unf_hit),
        .wm_reached (wm_reached),
        .evt        (irq_evt)
    );

    assign stat_word = DW'({ovf_q, unf_q, lvl_empty, lvl_full, wm_reached});

    always_comb begin
        if (b_addr == AW_BUS'(ADDR_POP))        b_rdata = lvl_empty ? '0 : head_word;
        else if (b_addr == AW_BUS'(ADDR_STAT))  b_rdata = stat_word;
        else if (b_addr == AW_BUS'(ADDR_WMARK)) b_rdata = DW'(wm_q);
        else                                    b_rdata = '0;
    end

endmodule

// File: rtl/mbx_word_fifo_chk.sv
module mbx_word_fifo_chk
    import mbx_word_fifo_pkg::*;
#(
    parameter  int DW     = 32,
    parameter  int DEPTH  = 32,
    parameter  int AW_BUS = 8,
    localparam int CW     = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_wr,
    input logic [AW_BUS-1:0] a_addr,
    input logic              b_rd,
    input logic [AW_BUS-1:0] b_addr,
    input logic [DW-1:0]     b_rdata,
    input logic [EV_W-1:0]   irq_evt,
    input logic [CW-1:0]     level,
    input logic              flush_req,
    input logic              err_of,
    input logic              err_uf
);

    logic push_a, pop_b;
    assign push_a = a_wr && (a_addr == AW_BUS'(ADDR_PUSH));
    assign pop_b  = b_rd && (b_addr == AW_BUS'(ADDR_POP));

    p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    p_uflow_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_b && level == '0) |-> b_rdata == '0);

    p_uflow_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_b && level == '0 && !flush_req) |=> irq_evt[EV_UFLOW] && err_uf);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_a && level == CW'(DEPTH) && !pop_b) |=> (level == CW'(DEPTH)) && irq_evt[EV_OFLOW]);

    p_wm_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_evt[EV_WMRISE] && irq_evt[EV_WMFALL]));

    p_empty_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt[EV_EMPTY] |-> level == '0);

    p_nempty_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt[EV_NEMPTY] |-> ($past(level) == '0 && level != '0));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (level == '0) && (irq_evt == '0) && !err_of && !err_uf);

    p_push_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_a && pop_b && level != '0 && !flush_req) |=> level == $past(level));

    p_oflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_of && !flush_req) |=> err_of);

    p_uflow_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_uf && !flush_req) |=> err_uf);

    p_low_bits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt[1:0] == 2'b00);

endmodule

bind mbx_word_fifo mbx_word_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .AW_BUS(AW_BUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_wr      (a_wr),
    .a_addr    (a_addr),
    .b_rd      (b_rd),
    .b_addr    (b_addr),
    .b_rdata   (b_rdata),
    .irq_evt   (irq_evt),
    .level     (level),
    .flush_req (flush_req),
    .err_of    (ovf_q),
    .err_uf    (unf_q)
);

// File: tb/test_mbx_word_fifo.sv
module test_mbx_word_fifo;
    import mbx_word_fifo_pkg::*;

    localparam int D = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr = 1'b0;
    logic [7:0]  a_addr = 8'h0;
    logic [31:0] a_wdata = 32'h0;
    logic        b_rd = 1'b0;
    logic [7:0]  b_addr = ADDR_STAT;
    logic [31:0] b_rdata;
    logic [8:0]  irq_evt;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    logic [31:0] mq[$];
    logic [5:0]  m_wm = 6'd32;
    bit          m_of = 1'b0, m_uf = 1'b0, m_wmf = 1'b0;

    mbx_word_fifo i_mbx_word_fifo (
        .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_rd(b_rd), .b_addr(b_addr), .b_rdata(b_rdata), .irq_evt(irq_evt)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string ev_tag(input int i);
        case (i)
            EV_FULL, EV_NEMPTY:   return "R7";
            EV_EMPTY:             return "R8";
            EV_WMRISE, EV_WMFALL: return "R6";
            EV_OFLOW:             return "R3";
            EV_UFLOW:             return "R4";
            default:              return "R12";
        endcase
    endfunction

    function automatic logic [31:0] exp_status();
        return {27'd0, m_of, m_uf, (mq.size() == 0), (mq.size() == D), m_wmf};
    endfunction

    // one cycle: port A op (push / wm write / flush write, exclusive) plus optional pop
    task automatic step(input bit push, input logic [31:0] pw, input bit pop,
                        input bit wmw, input logic [31:0] wmv,
                        input bit fl, input logic [31:0] flv);
        int old, nw;
        bit popok, pushok, flush_eff, wnew;
        logic [8:0] ev;
        @(negedge clk);
        a_wr    = push | wmw | fl;
        a_addr  = push ? ADDR_PUSH : (wmw ? ADDR_WMARK : ADDR_FLUSH);
        a_wdata = push ? pw : (wmw ? wmv : flv);
        b_rd    = pop;
        b_addr  = pop ? ADDR_POP : ADDR_STAT;
        #1;
        old = mq.size();
        if (pop) chk(old > 0 ? "R2 pop data" : "R4 empty pop data", b_rdata, old > 0 ? mq[0] : 32'd0);
        ev = '0;
        flush_eff = fl && flv[0];
        if (flush_eff) begin
            mq.delete();
            m_of = 1'b0;
            m_uf = 1'b0;
        end else begin
            popok  = pop && old > 0;
            pushok = push && (old < D || popok);
            if (popok) void'(mq.pop_front());
            if (pushok) mq.push_back(pw);
            nw = mq.size();
            ev[EV_OFLOW]  = push && !pushok;
            ev[EV_UFLOW]  = pop && old == 0;
            ev[EV_NEMPTY] = (old == 0 && nw > 0);
            ev[EV_FULL]   = (old < D && nw == D);
            ev[EV_EMPTY]  = (old > 0 && nw == 0);
            m_of = m_of | ev[EV_OFLOW];
            m_uf = m_uf | ev[EV_UFLOW];
        end
        if (wmw) m_wm = wmv[5:0];
        wnew = (mq.size() >= int'(m_wm));
        if (!flush_eff) begin
            ev[EV_WMRISE] = wnew && !m_wmf;
            ev[EV_WMFALL] = !wnew && m_wmf;
        end
        m_wmf = wnew;
        @(posedge clk);
        #1;
        a_wr = 1'b0;
        b_rd = 1'b0;
        b_addr = ADDR_STAT;
        #1;
        for (int i = 0; i < 9; i++) chk({ev_tag(i), " event bit"}, 32'(irq_evt[i]), 32'(ev[i]));
        chk("R5 status word", b_rdata, exp_status());
    endtask

    task automatic read_wm();
        @(negedge clk);
        b_rd = 1'b0;
        b_addr = ADDR_WMARK;
        #1;
        chk("R11 watermark readback", b_rdata, 32'(m_wm));
        b_addr = ADDR_STAT;
    endtask

    // watchdog
    initial begin
        #2000000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 status after reset", b_rdata, 32'h4);
        chk("R1 events after reset", 32'(irq_evt), 32'd0);
        read_wm();

        // R7 R3 R10 fill to full with default watermark, overflow, push+pop at full
        for (int k = 0; k < D; k++) step(1, 32'hA000_0000 + k, 0, 0, 0, 0, 0);
        step(1, 32'hDEAD_0001, 0, 0, 0, 0, 0);
        step(1, 32'hBEEF_0002, 1, 0, 0, 0, 0);
        // R8 R2 drain to empty, then R4 underflow
        for (int k = 0; k < D; k++) step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        // R4 pop of empty with simultaneous push
        step(1, 32'h1234_5678, 1, 0, 0, 0, 0);
        // R9 flush with bit0 clear has no effect, then real flush
        step(0, 0, 0, 0, 0, 1, 32'hFFFF_FFFE);
        step(0, 0, 0, 0, 0, 1, 32'h1);
        // R11 R6 watermark rewrite edges
        step(0, 0, 0, 1, 32'd3, 0, 0);
        read_wm();
        for (int k = 0; k < 3; k++) step(1, 32'h5000 + k, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 32'd1, 0, 0);
        step(0, 0, 0, 1, 32'd5, 0, 0);
        step(0, 0, 0, 1, 32'd0, 0, 0);
        read_wm();
        step(0, 0, 0, 0, 0, 1, 32'h1);

        // constrained random mix, phased to reach full and empty
        for (int s = 0; s < 4000; s++) begin
            int r;
            bit ps, pp;
            r  = $urandom_range(0, 99);
            ps = ((s / 150) % 2 == 0) ? (r < 70) : (r < 30);
            pp = ($urandom_range(0, 99) < (((s / 150) % 2 == 0) ? 30 : 70));
            if (r == 99 && ps == 0)
                step(0, 0, pp, 0, 0, 1, $urandom_range(0, 3));
            else if (r >= 95 && !ps)
                step(0, 0, pp, 1, $urandom_range(0, 33), 0, 0);
            else
                step(ps, $urandom, pp, 0, 0, 0, 0);
        end
        read_wm();

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule